// File: doc/BRIEF.md
# Tail-aware packed vector adder

This block adds two vector register values element by element with integer arithmetic. The register width is fixed by a parameter. A two-bit element-width code picks, at run time, how that width is cut into lanes of 8, 16, 32 or 64 bits. A length input gives the number of active lanes, counted from lane 0. Active lanes receive the wrapped sum of their two source lanes.

Every lane at or above that length is a tail lane. A policy bit chooses what a tail lane holds. Under the keep policy it holds the lane's value from the old destination vector. Under the fill policy it holds all ones, so the result is always deterministic.

The result is registered and comes out one cycle after an accepted input, together with a strobe. Reset is active-low and asynchronous, and its release is synchronised to the clock inside the block.

Top module: `tail_vadd`

## Requirements
- R1: Code `ew` 0, 1, 2 and 3 selects lanes of 8, 16, 32 and 64 bits. The lane count is VREG_W divided by the lane width, and lane n occupies bits [n*w +: w].
- R2: Each lane whose index is below the effective length receives (src_a lane + src_b lane) modulo 2^w.
- R3: No carry crosses a lane boundary. Carries inside a lane propagate normally across byte and word positions.
- R4: With `tail_agn` = 0, every tail lane equals the same lane of `old_dst`.
- R5: With `tail_agn` = 1, every tail lane is all ones.
- R6: When `vl` is 0, `result` equals `old_dst` under `tail_agn` = 0 and is all ones under `tail_agn` = 1.
- R7: A `vl` above the lane count for the selected width acts as the lane count, so every lane is active.
- R8: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high, and it carries that input's result. In cycles without `in_valid`, `result` keeps its value.
- R9: While reset is applied, and right after it, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| src_a | input | VREG_W | First source vector |
| src_b | input | VREG_W | Second source vector |
| old_dst | input | VREG_W | Prior destination contents |
| vl | input | $clog2(VREG_W/8)+2 | Number of active lanes |
| ew | input | 2 | Element width code (0:8, 1:16, 2:32, 3:64 bits) |
| tail_agn | input | 1 | Tail policy: 0 keep old, 1 fill with ones |
| out_valid | output | 1 | Result strobe |
| result | output | VREG_W | Registered result vector |

## Verification
The bench builds the block with its default VREG_W of 128, so `vl` is 6 bits wide. That gives 16, 8, 4 and 2 lanes across the four widths, and includes the 8-lane case with a length of 5. Because `vl` can reach 63, lengths well past every lane count can be driven to exercise clamping. Operands that carry across byte, word and lane boundaries separate the lane seams from the carry path inside a lane.

// File: rtl/tvadd_pkg.sv
package tvadd_pkg;
  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } ew_e;
endpackage

// File: rtl/tvadd_active_map.sv
module tvadd_active_map
  import tvadd_pkg::*;
#(
  parameter int NB  = 16,
  parameter int VLW = 6
) (
  input  logic [VLW-1:0] vl,
  input  ew_e            ew,
  output logic [NB-1:0]  byte_act,
  output logic [NB-1:0]  seg_start
);
  int lane_cnt;
  int vl_eff;
  int shamt;

  always_comb begin
    shamt    = int'(ew);
    lane_cnt = NB >> shamt;
    vl_eff   = (int'(vl) > lane_cnt) ? lane_cnt : int'(vl);
    for (int i = 0; i < NB; i++) begin
      byte_act[i]  = (i >> shamt) < vl_eff;
      seg_start[i] = (i % (1 << shamt)) == 0;
    end
  end

  // R2 active bytes form a contiguous run starting at byte 0
  always_comb begin
    act_prefix_chk: assert ((byte_act & (byte_act + 1'b1)) == '0);
  end
endmodule

// File: rtl/tvadd_seg_add.sv
module tvadd_seg_add #(
  parameter int NB = 16
) (
  input  logic [NB*8-1:0] a,
  input  logic [NB*8-1:0] b,
  input  logic [NB-1:0]   seg_start,
  output logic [NB*8-1:0] sum
);
  logic [NB-1:0] carry;

  assign carry[0] = 1'b0;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic cin;
    assign cin = seg_start[g] ? 1'b0 : carry[g];
    if (g < NB - 1) begin : g_mid
      logic [8:0] full;
      assign full           = {1'b0, a[g*8 +: 8]} + {1'b0, b[g*8 +: 8]} + {8'd0, cin};
      assign sum[g*8 +: 8]  = full[7:0];
      assign carry[g+1]     = full[8];
    end else begin : g_top
      assign sum[g*8 +: 8] = a[g*8 +: 8] + b[g*8 +: 8] + {7'd0, cin};
    end
  end
endmodule

// File: rtl/tvadd_tail_merge.sv
module tvadd_tail_merge #(
  parameter int NB = 16
) (
  input  logic [NB*8-1:0] sum,
  input  logic [NB*8-1:0] old_val,
  input  logic [NB-1:0]   byte_act,
  input  logic            fill_ones,
  output logic [NB*8-1:0] merged
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign merged[g*8 +: 8] = byte_act[g] ? sum[g*8 +: 8]
                            : (fill_ones ? 8'hFF : old_val[g*8 +: 8]);
  end
endmodule

// File: rtl/tail_vadd.sv
module tail_vadd
  import tvadd_pkg::*;
#(
  parameter int VREG_W = 128,
  localparam int NB    = VREG_W / 8,
  localparam int VLW   = $clog2(NB) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VREG_W-1:0] src_a,
  input  logic [VREG_W-1:0] src_b,
  input  logic [VREG_W-1:0] old_dst,
  input  logic [VLW-1:0]    vl,
  input  logic [1:0]        ew,
  input  logic              tail_agn,
  output logic              out_valid,
  output logic [VREG_W-1:0] result
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [NB-1:0]     byte_act;
  logic [NB-1:0]     seg_start;
  logic [VREG_W-1:0] sum;
  logic [VREG_W-1:0] merged;
  logic [VREG_W-1:0] res_d, res_q;
  logic              vld_d, vld_q;

  // reset: assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  tvadd_active_map #(.NB(NB), .VLW(VLW)) u_map (
    .vl        (vl),
    .ew        (ew_e'(ew)),
    .byte_act  (byte_act),
    .seg_start (seg_start)
  );

  tvadd_seg_add #(.NB(NB)) u_add (
    .a         (src_a),
    .b         (src_b),
    .seg_start (seg_start),
    .sum       (sum)
  );

  tvadd_tail_merge #(.NB(NB)) u_merge (
    .sum       (sum),
    .old_val   (old_dst),
    .byte_act  (byte_act),
    .fill_ones (tail_agn),
    .merged    (merged)
  );

  // next state
  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    if (in_valid) res_d = merged;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(result));
  // R6
  vl_zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && vl == '0 && !tail_agn) |=> (result == $past(old_dst)));
  // R6
  vl_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && vl == '0 && tail_agn) |=> (result == '1));
endmodule

// File: tb/tail_vadd_test.sv
`timescale 1ns/1ps
module tail_vadd_test;
  localparam int W   = 128;
  localparam int VLW = $clog2(W/8) + 2;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  logic           clk;
  logic           rst_n;
  logic           in_valid;
  logic [W-1:0]   src_a, src_b, old_dst;
  logic [VLW-1:0] vl;
  logic [1:0]     ew;
  logic           tail_agn;
  logic           out_valid;
  logic [W-1:0]   result;

  int checks;
  int errors;
  bit done;
  item_t sb[$];
  logic [W-1:0] last_exp;

  tail_vadd #(.VREG_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .old_dst(old_dst),
    .vl(vl), .ew(ew), .tail_agn(tail_agn),
    .out_valid(out_valid), .result(result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                         logic [W-1:0] o, int len, int code, bit agn);
    logic [W-1:0] acc;
    int w, nl, v;
    logic [63:0] mask;
    w    = 8 << code;
    nl   = W / w;
    v    = (len > nl) ? nl : len;
    mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    acc  = '0;
    for (int l = 0; l < nl; l++) begin
      logic [W-1:0] sa, sb2, so, tmp;
      logic [63:0] ea, eb, eo, er;
      sa  = a >> (l * w);
      sb2 = b >> (l * w);
      so  = o >> (l * w);
      ea  = sa[63:0] & mask;
      eb  = sb2[63:0] & mask;
      eo  = so[63:0] & mask;
      er  = (l < v) ? ((ea + eb) & mask) : (agn ? mask : eo);
      tmp = '0;
      tmp[63:0] = er;
      acc = acc | (tmp << (l * w));
    end
    return acc;
  endfunction

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] o,
                       int len, int code, bit agn, string tag);
    item_t it;
    src_a    = a;
    src_b    = b;
    old_dst  = o;
    vl       = VLW'(len);
    ew       = 2'(code);
    tail_agn = agn;
    in_valid = 1'b1;
    it.exp   = model(a, b, o, len, code, agn);
    it.tag   = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R8 unexpected out_valid: actual 1 expected 0");
        end else begin
          item_t it;
          it = sb.pop_front();
          last_exp = it.exp;
          if (result !== it.exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", it.tag, result, it.exp);
          end
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 50000; c++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pa, pb, po;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; src_a = '0; src_b = '0; old_dst = '0;
    vl = '0; ew = '0; tail_agn = 1'b0; last_exp = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset out_valid actual %b expected 0", out_valid);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R9 after reset out_valid actual %b expected 0", out_valid);
    end

    pa = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    pb = 128'h1111_2222_3333_4444_F0F0_0F0F_8888_7777;
    po = 128'hA5A5_5A5A_C3C3_3C3C_9696_6969_DEAD_BEEF;

    // R2 R3: bytes wrap without touching neighbours
    drive({16{8'hFF}}, {16{8'h01}}, po, 16, 0, 1'b0, "R3 byte wrap");
    idle(1);
    // R4 R1: 8 lanes of 16 bits, length 5
    drive(pa, pb, po, 5, 1, 1'b0, "R4 ew16 vl5 keep");
    idle(1);
    // R5
    drive(pa, pb, po, 5, 1, 1'b1, "R5 ew16 vl5 fill");
    // R3: lane 0 of 16 bits overflows, lane 1 zero
    drive(128'h0000_FFFF, 128'h0000_0001, po, 8, 1, 1'b0, "R3 ew16 seam");
    // R1 R2: 32-bit lanes
    drive(pa, pb, po, 3, 2, 1'b1, "R2 ew32 vl3 fill");
    // R3: carry inside a 64-bit lane across a 32-bit seam
    drive(128'h0000_0000_FFFF_FFFF, 128'h1, po, 1, 3, 1'b0, "R3 ew64 inner carry");
    idle(2);
    // R6
    drive(pa, pb, po, 0, 2, 1'b0, "R6 vl0 keep");
    drive(pa, pb, po, 0, 0, 1'b1, "R6 vl0 fill");
    // R7
    drive(pa, pb, po, 40, 0, 1'b1, "R7 ew8 clamp");
    drive(pa, pb, po, 9, 3, 1'b0, "R7 ew64 clamp");
    drive(pa, pb, po, 63, 2, 1'b1, "R7 ew32 clamp");
    // R2 R4: mixed patterns back to back
    drive(pb, po, pa, 11, 0, 1'b0, "R4 ew8 vl11 keep");
    drive(po, pa, pb, 2, 1, 1'b1, "R5 ew16 vl2 fill");
    drive({2{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'h1}}, po, 2, 3, 1'b0, "R2 ew64 wrap");
    idle(4);
    // R8 result holds during idle
    checks++;
    if (result !== last_exp) begin
      errors++;
      $display("FAIL R8 hold actual %h expected %h", result, last_exp);
    end
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R8 missing results actual %0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule